// File: doc/BRIEF.md
# QPSK Differential Decoder and Serializer

This block sits behind a QPSK demodulator's slicer. Each time the symbol strobe fires, it takes one hard decision: the sign bit of I and the sign bit of Q. It turns that decision into a quadrant index and compares it with the quadrant of the symbol before. The phase step between the two symbols is mapped back to a two-bit data value. A static select input picks the mapping. In normal mode a +90° step decodes to 10 and a -90° step to 01. In inverted-spectrum mode those two codes swap. This corrects for a receiver that processes a mirrored image of the IF.

Each decoded dibit is then sent out on one serial line, most significant bit first. A generated bit clock goes with it, and a valid qualifier marks bits that come from a locked, phase-referenced symbol. The decoder holds a controller with three states:
- `DD_UNLOCK`: lock is low.
- `DD_REFWAIT`: lock is high but no reference symbol has been taken yet.
- `DD_TRACK`: steps are being decoded.

Its transitions are:
- `lock_lost`: from any state to `DD_UNLOCK` when lock is low.
- `lock_seen`: `DD_UNLOCK` to `DD_REFWAIT` when lock is high and no strobe is present.
- `ref_taken`: `DD_UNLOCK` or `DD_REFWAIT` to `DD_TRACK` when lock is high and a strobe arrives.

The serializer controller walks through `SR_IDLE`, then `SR_B0_LO`, `SR_B0_HI`, `SR_B1_LO` and `SR_B1_HI`. Each of the four bit-phase states lasts `HALF_DIV` clock cycles. The serializer has three transitions:
- `start`: `SR_IDLE` to `SR_B0_LO` when a dibit is waiting.
- `next_half`: from each bit-phase state to the next one when its half period ends.
- `chain` / `drain`: from `SR_B1_HI` back to `SR_B0_LO` if another dibit is waiting, otherwise to `SR_IDLE`.

Top module: `qpsk_diff_serializer`

## Requirements
- R1: The quadrant index is formed from the sign bits `sym_i` and `sym_q` (1 = negative), counterclockwise: (0,0)=0, (1,0)=1, (1,1)=2, (0,1)=3. The phase step is (current − previous) mod 4, where 1 means +90°, 2 means 180° and 3 means −90°.
- R2: With `inv_sel`=0, the step decodes as follows: 0 gives dibit 00, +90° gives 10, 180° gives 11 and −90° gives 01.
- R3: With `inv_sel`=1, +90° decodes to 01 and −90° to 10. A step of 0 still gives 00 and 180° still gives 11.
- R4: The first strobed symbol while lock is high, after reset or after lock was lost, is only a phase reference. Its dibit is sent as 00 with valid low.
- R5: A symbol strobed while `lock_in` is low yields dibit 00 with valid low. Any cycle with lock low forces a new reference.
- R6: Every strobe produces exactly two serial bits, the dibit's left bit first. Each bit spends `HALF_DIV` cycles with `ser_clk` low and then `HALF_DIV` cycles with it high.
- R7: `ser_data` changes only while `ser_clk` is low and is stable across each rising edge of `ser_clk`.
- R8: `ser_valid` during a bit equals the valid flag of the dibit that bit belongs to.
- R9: With no dibit waiting, `ser_clk`, `ser_data` and `ser_valid` rest at 0.
- R10: A dibit that arrives while another is being sent is held and sent directly after it. With strobes every 4·`HALF_DIV` cycles, no dibit is lost.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Processing clock |
| rst_n | input | 1 | Asynchronous active-low reset |
| sym_stb | input | 1 | One-cycle strobe marking a new symbol decision |
| sym_i | input | 1 | Sign of the I decision (1 = negative) |
| sym_q | input | 1 | Sign of the Q decision (1 = negative) |
| lock_in | input | 1 | Upstream tracking loops locked |
| inv_sel | input | 1 | 1 selects the inverted-spectrum mapping |
| ser_data | output | 1 | Serial data, left dibit bit first |
| ser_clk | output | 1 | Bit clock; data is sampled on its rising edge |
| ser_valid | output | 1 | Current serial bit comes from a valid dibit |

## Verification
Directed sequences visit all four absolute quadrants and step through 0°, +90°, 180° and −90° in both mapping modes. Only the +90° and −90° steps tell the two modes apart, and only a wrong quadrant order or a wrong subtraction direction would swap them. Lock is dropped between strobes and also at a strobe. This separates a symbol that is merely unlocked from the reference symbol that follows re-lock. Random sequences of quadrants, with lock drops, mode flips and gaps that are either back-to-back or long, compare every bit taken at a rising `ser_clk` edge against a scoreboard. The idle gaps show that the line goes quiet, and the back-to-back runs show that no held dibit is dropped or reordered.

// File: rtl/qpsk_dd_pkg.sv
package qpsk_dd_pkg;

    // Counterclockwise quadrant index
    typedef logic [1:0] quad_t;

    // Phase step between consecutive symbols, modulo 4
    typedef enum logic [1:0] {
        PH_ZERO = 2'd0,
        PH_P90  = 2'd1,
        PH_180  = 2'd2,
        PH_M90  = 2'd3
    } phase_step_e;

    typedef enum logic [1:0] {
        DD_UNLOCK  = 2'd0,
        DD_REFWAIT = 2'd1,
        DD_TRACK   = 2'd2
    } dd_state_e;

    typedef enum logic [2:0] {
        SR_IDLE  = 3'd0,
        SR_B0_LO = 3'd1,
        SR_B0_HI = 3'd2,
        SR_B1_LO = 3'd3,
        SR_B1_HI = 3'd4
    } sr_state_e;

    typedef logic [1:0] dibit_t;

endpackage

// File: rtl/qpsk_quadrant.sv
module qpsk_quadrant
    import qpsk_dd_pkg::*;
(
    input  logic  i_neg,
    input  logic  q_neg,
    output quad_t quad
);

    // Sign pair to counterclockwise index (a Gray-coded walk)
    always_comb begin
        unique case ({i_neg, q_neg})
            2'b00:   quad = 2'd0;
            2'b10:   quad = 2'd1;
            2'b11:   quad = 2'd2;
            default: quad = 2'd3;
        endcase
    end

endmodule

// File: rtl/qpsk_dibit_map.sv
module qpsk_dibit_map
    import qpsk_dd_pkg::*;
(
    input  quad_t  cur_quad,
    input  quad_t  prev_quad,
    input  logic   inv_mode,
    output dibit_t dibit
);

    phase_step_e step;
    quad_t       diff;

    assign diff = cur_quad - prev_quad;

    always_comb begin
        step = phase_step_e'(diff);
        unique case (step)
            PH_ZERO: dibit = 2'b00;
            PH_180:  dibit = 2'b11;
            PH_P90:  dibit = inv_mode ? 2'b01 : 2'b10;
            PH_M90:  dibit = inv_mode ? 2'b10 : 2'b01;
            default: dibit = 2'b00;
        endcase
    end

endmodule

// File: rtl/qpsk_diff_fsm.sv
module qpsk_diff_fsm
    import qpsk_dd_pkg::*;
(
    input  logic   clk,
    input  logic   rst_n,
    input  logic   sym_stb,
    input  quad_t  quad,
    input  logic   lock_in,
    input  logic   inv_sel,
    output logic   dib_stb,
    output dibit_t dib,
    output logic   dib_ok
);

    dd_state_e state, state_nxt;
    quad_t     prev_quad;
    dibit_t    mapped;

    qpsk_dibit_map map_i (
        .cur_quad  (quad),
        .prev_quad (prev_quad),
        .inv_mode  (inv_sel),
        .dibit     (mapped)
    );

    // Transitions: lock_lost, lock_seen, ref_taken
    always_comb begin
        state_nxt = state;
        if (!lock_in) begin
            state_nxt = DD_UNLOCK;
        end else begin
            unique case (state)
                DD_UNLOCK:  state_nxt = sym_stb ? DD_TRACK : DD_REFWAIT;
                DD_REFWAIT: state_nxt = sym_stb ? DD_TRACK : DD_REFWAIT;
                DD_TRACK:   state_nxt = DD_TRACK;
                default:    state_nxt = DD_UNLOCK;
            endcase
        end
    end

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) state <= DD_UNLOCK;
        else        state <= state_nxt;
    end

    // Output process: one registered dibit per strobe
    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) begin
            dib_stb   <= 1'b0;
            dib       <= 2'b00;
            dib_ok    <= 1'b0;
            prev_quad <= 2'd0;
        end else begin
            dib_stb <= sym_stb;
            if (sym_stb) begin
                prev_quad <= quad;
                if (lock_in && state == DD_TRACK) begin
                    dib    <= mapped;
                    dib_ok <= 1'b1;
                end else begin
                    dib    <= 2'b00;
                    dib_ok <= 1'b0;
                end
            end
        end
    end

endmodule

// File: rtl/qpsk_bit_serializer.sv
module qpsk_bit_serializer
    import qpsk_dd_pkg::*;
#(
    parameter int HALF_DIV = 2
) (
    input  logic   clk,
    input  logic   rst_n,
    input  logic   dib_stb,
    input  dibit_t dib,
    input  logic   dib_ok,
    output logic   ser_data,
    output logic   ser_clk,
    output logic   ser_valid
);

    localparam int CW = (HALF_DIV > 1) ? $clog2(HALF_DIV) : 1;
    localparam logic [CW-1:0] CNT_LAST = CW'(HALF_DIV - 1);

    sr_state_e   state, state_nxt;
    logic [CW-1:0] cnt;
    logic        half_done;
    dibit_t      shreg;
    logic        vld_r;
    logic        pend_full;
    dibit_t      pend_dib;
    logic        pend_ok;
    logic        take_new;
    dibit_t      new_dib;
    logic        new_ok;
    logic        load;

    // Half-period end: a counter only when a half spans several cycles
    generate
        if (HALF_DIV > 1) begin : g_div
            assign half_done = (cnt == CNT_LAST);
        end else begin : g_nodiv
            assign half_done = 1'b1;
        end
    endgenerate

    assign take_new = dib_stb | pend_full;
    assign new_dib  = dib_stb ? dib    : pend_dib;
    assign new_ok   = dib_stb ? dib_ok : pend_ok;

    // Transitions: start, next_half, chain, drain
    always_comb begin
        state_nxt = state;
        unique case (state)
            SR_IDLE:  if (take_new)  state_nxt = SR_B0_LO;
            SR_B0_LO: if (half_done) state_nxt = SR_B0_HI;
            SR_B0_HI: if (half_done) state_nxt = SR_B1_LO;
            SR_B1_LO: if (half_done) state_nxt = SR_B1_HI;
            SR_B1_HI: if (half_done) state_nxt = take_new ? SR_B0_LO : SR_IDLE;
            default:  state_nxt = SR_IDLE;
        endcase
    end

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) state <= SR_IDLE;
        else        state <= state_nxt;
    end

    assign load = take_new &&
                  ((state == SR_IDLE) || (state == SR_B1_HI && half_done));

    // Output process: counter, shift register, hold slot, bit clock
    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) begin
            cnt       <= '0;
            shreg     <= 2'b00;
            vld_r     <= 1'b0;
            pend_full <= 1'b0;
            pend_dib  <= 2'b00;
            pend_ok   <= 1'b0;
            ser_clk   <= 1'b0;
        end else begin
            if (state_nxt != state || state == SR_IDLE) cnt <= '0;
            else                                         cnt <= cnt + 1'b1;

            if (load) begin
                shreg     <= new_dib;
                vld_r     <= new_ok;
                pend_full <= 1'b0;
            end else begin
                if (dib_stb) begin
                    pend_full <= 1'b1;
                    pend_dib  <= dib;
                    pend_ok   <= dib_ok;
                end
                if (state == SR_B0_HI && half_done) begin
                    shreg <= {shreg[0], 1'b0};
                end else if (state == SR_B1_HI && half_done) begin
                    shreg <= 2'b00;
                    vld_r <= 1'b0;
                end
            end

            ser_clk <= (state_nxt == SR_B0_HI) || (state_nxt == SR_B1_HI);
        end
    end

    assign ser_data  = shreg[1];
    assign ser_valid = vld_r;

endmodule

// File: rtl/qpsk_diff_serializer.sv
module qpsk_diff_serializer
    import qpsk_dd_pkg::*;
#(
    parameter int HALF_DIV = 2
) (
    input  logic clk,
    input  logic rst_n,
    input  logic sym_stb,
    input  logic sym_i,
    input  logic sym_q,
    input  logic lock_in,
    input  logic inv_sel,
    output logic ser_data,
    output logic ser_clk,
    output logic ser_valid
);

    quad_t  quad;
    logic   dib_stb;
    dibit_t dib;
    logic   dib_ok;

    qpsk_quadrant quad_i (
        .i_neg (sym_i),
        .q_neg (sym_q),
        .quad  (quad)
    );

    qpsk_diff_fsm dec_i (
        .clk     (clk),
        .rst_n   (rst_n),
        .sym_stb (sym_stb),
        .quad    (quad),
        .lock_in (lock_in),
        .inv_sel (inv_sel),
        .dib_stb (dib_stb),
        .dib     (dib),
        .dib_ok  (dib_ok)
    );

    qpsk_bit_serializer #(.HALF_DIV(HALF_DIV)) ser_i (
        .clk       (clk),
        .rst_n     (rst_n),
        .dib_stb   (dib_stb),
        .dib       (dib),
        .dib_ok    (dib_ok),
        .ser_data  (ser_data),
        .ser_clk   (ser_clk),
        .ser_valid (ser_valid)
    );

endmodule

// File: rtl/qpsk_dd_checker.sv
module qpsk_dd_checker (
    input logic       clk,
    input logic       rst_n,
    input logic       sym_stb,
    input logic       lock_in,
    input logic       dib_stb,
    input logic [1:0] dib,
    input logic       dib_ok,
    input logic       ser_data,
    input logic       ser_clk
);

    // R6
    stb_to_dibit_chk: assert property (@(posedge clk) disable iff (!rst_n)
        sym_stb |=> dib_stb);

    // R5
    unlocked_invalid_chk: assert property (@(posedge clk) disable iff (!rst_n)
        (sym_stb && !lock_in) |=> (!dib_ok && dib == 2'b00));

    // R5
    valid_needs_lock_chk: assert property (@(posedge clk) disable iff (!rst_n)
        (dib_stb && dib_ok) |-> $past(lock_in));

    // R7
    data_moves_low_chk: assert property (@(posedge clk) disable iff (!rst_n)
        !$stable(ser_data) |-> !ser_clk);

    // R7
    data_still_at_rise_chk: assert property (@(posedge clk) disable iff (!rst_n)
        $rose(ser_clk) |-> $stable(ser_data));

endmodule

bind qpsk_diff_serializer qpsk_dd_checker chk_i (
    .clk      (clk),
    .rst_n    (rst_n),
    .sym_stb  (sym_stb),
    .lock_in  (lock_in),
    .dib_stb  (dib_stb),
    .dib      (dib),
    .dib_ok   (dib_ok),
    .ser_data (ser_data),
    .ser_clk  (ser_clk)
);

// File: tb/qpsk_diff_serializer_tb_top.sv
module qpsk_diff_serializer_tb_top;

    localparam int HALF_DIV = 2;
    localparam int SYM_GAP  = 4 * HALF_DIV;

    logic clk = 1'b0;
    logic rst_n = 1'b0;
    logic sym_stb = 1'b0, sym_i = 1'b0, sym_q = 1'b0;
    logic lock_in = 1'b0, inv_sel = 1'b0;
    logic ser_data, ser_clk, ser_valid;

    int checks = 0;
    int errors = 0;

    logic [1:0] exp_q[$];   // {valid, data}
    string      tag_q[$];
    bit         had_ref = 0;
    logic [1:0] prev_idx = 2'd0;
    logic       last_clk = 1'b0;
    int         hi_len = 0;
    bit         done = 0;

    always #4 clk = ~clk;

    qpsk_diff_serializer #(.HALF_DIV(HALF_DIV)) dut_i (
        .clk(clk), .rst_n(rst_n), .sym_stb(sym_stb), .sym_i(sym_i),
        .sym_q(sym_q), .lock_in(lock_in), .inv_sel(inv_sel),
        .ser_data(ser_data), .ser_clk(ser_clk), .ser_valid(ser_valid));

    task automatic check(input bit ok, input string req, input int act, input int exp);
        checks++;
        if (!ok) begin
            errors++;
            $display("FAIL %s actual=%0d expected=%0d at %0t", req, act, exp, $time);
        end
    endtask

    // R1: counterclockwise quadrant index from sign bits
    function automatic logic [1:0] idx_of(input logic i_neg, input logic q_neg);
        if (!i_neg && !q_neg) return 2'd0;
        if ( i_neg && !q_neg) return 2'd1;
        if ( i_neg &&  q_neg) return 2'd2;
        return 2'd3;
    endfunction

    // R2 / R3 dibit tables
    function automatic logic [1:0] exp_dibit(input logic [1:0] cur, input logic [1:0] prv,
                                             input logic inv);
        logic [1:0] stepv;
        stepv = cur - prv;
        case (stepv)
            2'd0: return 2'b00;
            2'd2: return 2'b11;
            2'd1: return inv ? 2'b01 : 2'b10;
            default: return inv ? 2'b10 : 2'b01;
        endcase
    endfunction

    task automatic push_dibit(input logic v, input logic [1:0] d, input string tag);
        exp_q.push_back({v, d[1]}); tag_q.push_back(tag);
        exp_q.push_back({v, d[0]}); tag_q.push_back(tag);
    endtask

    task automatic send_sym(input logic i_neg, input logic q_neg, input logic lk,
                            input logic inv, input int gap, input string tag);
        logic [1:0] cur;
        @(negedge clk);
        sym_i = i_neg; sym_q = q_neg; lock_in = lk; inv_sel = inv; sym_stb = 1'b1;
        cur = idx_of(i_neg, q_neg);
        if (!lk) begin
            had_ref = 0;
            push_dibit(1'b0, 2'b00, "R5 unlocked symbol");
        end else if (!had_ref) begin
            had_ref = 1;
            push_dibit(1'b0, 2'b00, "R4 reference symbol");
        end else begin
            push_dibit(1'b1, exp_dibit(cur, prev_idx, inv), tag);
        end
        prev_idx = cur;
        @(negedge clk);
        sym_stb = 1'b0;
        repeat (gap - 2) @(negedge clk);
    endtask

    task automatic drop_lock(input int cycles);
        @(negedge clk);
        lock_in = 1'b0;
        had_ref = 0;
        repeat (cycles) @(negedge clk);
        lock_in = 1'b1;
    endtask

    // Bit monitor: samples away from the active edge
    always @(negedge clk) begin
        if (rst_n && !done) begin
            if (ser_clk && !last_clk) begin
                if (exp_q.size() == 0) begin
                    check(1'b0, "R6 unexpected bit", 1, 0);
                end else begin
                    logic [1:0] e;
                    string      t;
                    e = exp_q.pop_front();
                    t = tag_q.pop_front();
                    // R8: valid qualifier per bit
                    check(ser_valid == e[1], {"R8 valid for ", t}, ser_valid, e[1]);
                    check(ser_data == e[0], {"R6 bit value for ", t}, ser_data, e[0]);
                end
            end
            if (ser_clk) hi_len++;
            if (!ser_clk && last_clk) begin
                check(hi_len == HALF_DIV, "R6 high-phase length", hi_len, HALF_DIV);
                hi_len = 0;
            end
            last_clk = ser_clk;
        end
    end

    initial begin
        repeat (200000) @(posedge clk);
        errors++; checks++;
        $display("FAIL watchdog expired");
        $display("  Simulation finished: %0d checks, %0d errors", checks, errors);
        $finish;
    end

    initial begin
        repeat (3) @(negedge clk);
        // R9: rest state straight after reset
        check(ser_clk == 0 && ser_data == 0 && ser_valid == 0, "R9 reset state",
              {ser_clk, ser_data, ser_valid}, 0);
        rst_n = 1'b1;
        repeat (2) @(negedge clk);
        check(ser_clk == 0 && ser_valid == 0, "R9 quiet after reset",
              {ser_clk, ser_valid}, 0);

        // R1 / R2: walk all quadrants, normal mapping
        send_sym(0, 0, 1, 0, SYM_GAP, "R1 R2");     // reference at index 0
        send_sym(1, 0, 1, 0, SYM_GAP, "R2 +90");    // 0->1
        send_sym(0, 1, 1, 0, SYM_GAP, "R2 180");    // 1->3
        send_sym(1, 1, 1, 0, SYM_GAP, "R2 -90");    // 3->2
        send_sym(1, 1, 1, 0, SYM_GAP, "R2 zero");   // 2->2
        send_sym(0, 1, 1, 0, SYM_GAP, "R1 +90");    // 2->3
        send_sym(0, 0, 1, 0, SYM_GAP, "R1 wrap");   // 3->0 is +90
        // R3: inverted mapping
        send_sym(0, 1, 1, 1, SYM_GAP, "R3 -90");
        send_sym(0, 0, 1, 1, SYM_GAP, "R3 +90");
        send_sym(1, 1, 1, 1, SYM_GAP, "R3 180");
        send_sym(1, 1, 1, 1, SYM_GAP, "R3 zero");

        // R5 then R4: lock lost between strobes, strobe while unlocked, relock
        drop_lock(3);
        send_sym(1, 0, 0, 0, SYM_GAP, "R5");
        send_sym(0, 1, 1, 0, SYM_GAP, "R4");
        send_sym(0, 0, 1, 0, SYM_GAP, "R2 after relock");

        // R9: long gap, line must rest
        repeat (30) @(negedge clk);
        check(exp_q.size() == 0, "R10 queue drained", exp_q.size(), 0);
        check(ser_clk == 0 && ser_data == 0 && ser_valid == 0, "R9 idle line",
              {ser_clk, ser_data, ser_valid}, 0);

        // Random mix: R10 back-to-back and gapped strobes
        begin
            int unsigned seed_dummy;
            logic inv_r;
            seed_dummy = $urandom(32'h5eed_1234);
            inv_r = 1'b0;
            for (int n = 0; n < 400; n++) begin
                int r;
                int gap;
                r = $urandom_range(99);
                if (r < 4) drop_lock($urandom_range(1, 5));
                if (r >= 95) inv_r = ~inv_r;
                gap = ($urandom_range(3) == 0) ? SYM_GAP + $urandom_range(12) : SYM_GAP;
                send_sym($urandom_range(1), $urandom_range(1), 1'b1, inv_r, gap,
                         inv_r ? "R3 random" : "R2 random R10");
            end
        end

        repeat (40) @(negedge clk);
        check(exp_q.size() == 0, "R10 all dibits sent", exp_q.size(), 0);
        check(ser_clk == 0 && ser_valid == 0, "R9 final idle", {ser_clk, ser_valid}, 0);
        done = 1;
        $display("  Simulation finished: %0d checks, %0d errors", checks, errors);
        $finish;
    end

endmodule